// File: doc/BRIEF.md
# Replay Trace Divergence Checker

This block helps locate a faulty core after a software-visible symptom. During a record window it captures a compact trace of one thread. Only branch, load and store events are kept, because those are the points where a hardware fault becomes visible to software. Every load value is kept as well. A later replay of the same thread, on a different core, can then be fed exactly the data it saw the first time. Because each thread is replayed alone, no memory-ordering information is needed.

In replay mode the block acts as a load-value source for the replaying core. It also compares each replayed event against the recorded one. The first difference is latched together with its position in the trace and both versions of the event. The diverging core is the one whose execution differs from the recorded run. Storage is bounded, so firmware walks a long execution as a series of short windows and starts a fresh window each time one is consumed.

Top module: `trace_div_checker`

## Requirements
- R1: After reset or a cycle with `win_start_i` high, `rec_count_o` is 0 and `win_full_o`, `diverged_o`, `match_done_o` and `ld_avail_o` are low.
- R2: Mode encoding is 0 idle, 1 record, 2 replay, 3 idle. Each `ev_valid_i` cycle in record mode adds one entry, and `rec_count_o` shows the new count after the clock edge. Events in any other mode leave `rec_count_o` unchanged.
- R3: When `rec_count_o` reaches DEPTH, `win_full_o` goes high. Further record events are dropped until the next window start.
- R4: In replay mode, `ld_avail_o` is high while recorded load values remain. `ld_data_o` shows the values of the recorded load entries (kind 1) in program order, and each `ld_req_i` cycle moves to the next value. When no value remains, `ld_avail_o` is low and `ld_data_o` is 0.
- R5: When the replayed event that matches the last recorded entry is accepted, `match_done_o` is high for exactly the one cycle after that edge. It stays low if any divergence was found.
- R6: The first replayed event whose kind, address or data differs from the recorded entry at the same position sets `diverged_o`. It also latches the 0-based position on `div_index_o`, the recorded entry on `div_exp_*` and the replayed event on `div_got_*`. All of these are visible after the same clock edge.
- R7: Once `diverged_o` is set, later replayed events do not change any divergence output and do not raise `match_done_o`.
- R8: A replayed event that arrives after all recorded entries have been matched is a divergence. Its expected kind, address and data are reported as 0.
- R9: Event kinds are 0 branch, 1 load and 2 store. For a branch, the data field carries the taken flag in bit 0. A difference in kind alone is a divergence.
- R10: The cycle in which the mode changes to replay rewinds the compare position and the load-value position to the start of the window. It also clears `diverged_o`, and no event is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 idle, 1 record, 2 replay, 3 idle |
| win_start_i | input | 1 | Starts a new window and discards the stored trace |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_kind_i | input | 2 | 0 branch, 1 load, 2 store |
| ev_addr_i | input | 64 | Address or branch target |
| ev_data_i | input | 64 | Load/store data, or branch taken flag in bit 0 |
| ld_req_i | input | 1 | Replaying core consumes one recorded load value |
| ld_avail_o | output | 1 | A recorded load value is available |
| ld_data_o | output | 64 | Next recorded load value |
| rec_count_o | output | IW | Number of recorded entries in the window |
| win_full_o | output | 1 | Window storage is full |
| match_done_o | output | 1 | One-cycle pulse when the whole window replayed without a difference |
| diverged_o | output | 1 | A divergence was latched |
| div_index_o | output | IW | Position of the first diverging entry |
| div_exp_kind_o | output | 2 | Recorded kind at the divergence |
| div_exp_addr_o | output | 64 | Recorded address at the divergence |
| div_exp_data_o | output | 64 | Recorded data at the divergence |
| div_got_kind_o | output | 2 | Replayed kind at the divergence |
| div_got_addr_o | output | 64 | Replayed address at the divergence |
| div_got_data_o | output | 64 | Replayed data at the divergence |

## Verification
The bench checks that a difference only in the store data at the third entry reports position 2 with both data values. A comparator that advanced on mismatch, or that latched the second difference, would report a later position. It then sends correct events after the divergence and expects the latched fields to hold with no completion pulse. A design without stickiness would overwrite them or report a match. A replay one event longer than the recording must diverge at the position just past the end, with expected fields zero. A design that wraps its read pointer would compare against entry 0 instead. Filling the window beyond its depth must leave the count at the depth, and load values must come back in order while store and branch data are skipped.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int TRC_AW = 64;
    localparam int TRC_DW = 64;

    typedef enum logic [1:0] {
        EV_BRANCH = 2'd0,
        EV_LOAD   = 2'd1,
        EV_STORE  = 2'd2,
        EV_RSVD   = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_RECORD = 2'd1,
        MODE_REPLAY = 2'd2,
        MODE_SPARE  = 2'd3
    } trc_mode_e;

    typedef struct packed {
        ev_kind_e            kind;
        logic [TRC_AW-1:0]   addr;
        logic [TRC_DW-1:0]   data;
    } trc_ent_t;

    function automatic logic ent_differs(trc_ent_t a, trc_ent_t b);
        return (a.kind != b.kind) || (a.addr != b.addr) || (a.data != b.data);
    endfunction

    function automatic logic ent_is_load(trc_ent_t e);
        return e.kind == EV_LOAD;
    endfunction

endpackage

// File: rtl/trc_store.sv
module trc_store
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  trc_ent_t          wr_ent,
    input  logic [PW-1:0]     rd_idx,
    output trc_ent_t          rd_ent,
    input  logic [PW-1:0]     lrd_idx,
    output logic [TRC_DW-1:0] lrd_val,
    output logic [IW-1:0]     count,
    output logic [IW-1:0]     lcount,
    output logic              full
);

    localparam logic [IW-1:0] CAP = IW'(DEPTH);

    logic [IW-1:0]     cnt_q;
    logic [IW-1:0]     lcnt_q;
    trc_ent_t          ent_mem  [DEPTH];
    logic [TRC_DW-1:0] lval_mem [DEPTH];
    logic              accept;
    logic              ld_accept;

    assign full      = (cnt_q == CAP);
    assign accept    = wr_en && !full;
    assign ld_accept = accept && ent_is_load(wr_ent);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (accept && (cnt_q[PW-1:0] == PW'(g))) begin
                ent_mem[g] <= wr_ent;
            end
            if (ld_accept && (lcnt_q[PW-1:0] == PW'(g))) begin
                lval_mem[g] <= wr_ent.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            lcnt_q <= '0;
        end else begin
            if (accept)    cnt_q  <= cnt_q + 1'b1;
            if (ld_accept) lcnt_q <= lcnt_q + 1'b1;
        end
    end

    assign rd_ent  = ent_mem[rd_idx];
    assign lrd_val = lval_mem[lrd_idx];
    assign count   = cnt_q;
    assign lcount  = lcnt_q;

endmodule

// File: rtl/trc_load_feed.sv
module trc_load_feed
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic              req,
    input  logic [IW-1:0]     lcount,
    input  logic [TRC_DW-1:0] mem_val,
    output logic [PW-1:0]     mem_idx,
    output logic              avail,
    output logic [TRC_DW-1:0] value
);

    logic [IW-1:0] ptr_q;
    logic          remain;

    assign remain  = (ptr_q < lcount);
    assign avail   = active && remain;
    assign mem_idx = ptr_q[PW-1:0];
    assign value   = avail ? mem_val : '0;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q <= '0;
        end else if (req && avail) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/trc_compare.sv
module trc_compare
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH + 1),
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ev_en,
    input  trc_ent_t      got,
    input  logic [IW-1:0] count,
    input  trc_ent_t      rec_ent,
    output logic [PW-1:0] rd_idx,
    output logic          diverged,
    output logic [IW-1:0] div_index,
    output trc_ent_t      div_exp,
    output trc_ent_t      div_got,
    output logic          match_done
);

    logic [IW-1:0] cptr_q;
    logic          in_range;
    trc_ent_t      exp_eff;
    logic          mismatch;

    assign in_range = (cptr_q < count);
    assign rd_idx   = cptr_q[PW-1:0];
    assign exp_eff  = in_range ? rec_ent : '0;
    assign mismatch = !in_range || ent_differs(exp_eff, got);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cptr_q     <= '0;
            diverged   <= 1'b0;
            div_index  <= '0;
            div_exp    <= '0;
            div_got    <= '0;
            match_done <= 1'b0;
        end else begin
            match_done <= 1'b0;
            if (ev_en && !diverged) begin
                if (mismatch) begin
                    diverged  <= 1'b1;
                    div_index <= cptr_q;
                    div_exp   <= exp_eff;
                    div_got   <= got;
                end else begin
                    cptr_q     <= cptr_q + 1'b1;
                    match_done <= ((cptr_q + 1'b1) == count);
                end
            end
        end
    end

endmodule

// File: rtl/trace_div_checker.sv
module trace_div_checker
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              win_start_i,
    input  logic              ev_valid_i,
    input  logic [1:0]        ev_kind_i,
    input  logic [TRC_AW-1:0] ev_addr_i,
    input  logic [TRC_DW-1:0] ev_data_i,
    input  logic              ld_req_i,
    output logic              ld_avail_o,
    output logic [TRC_DW-1:0] ld_data_o,
    output logic [IW-1:0]     rec_count_o,
    output logic              win_full_o,
    output logic              match_done_o,
    output logic              diverged_o,
    output logic [IW-1:0]     div_index_o,
    output logic [1:0]        div_exp_kind_o,
    output logic [TRC_AW-1:0] div_exp_addr_o,
    output logic [TRC_DW-1:0] div_exp_data_o,
    output logic [1:0]        div_got_kind_o,
    output logic [TRC_AW-1:0] div_got_addr_o,
    output logic [TRC_DW-1:0] div_got_data_o
);

    trc_mode_e mode;
    trc_mode_e prev_mode_q;
    logic      in_replay;
    logic      replay_enter;
    logic      clr_replay;
    logic      rec_wr;
    logic      cmp_en;
    trc_ent_t  ev_ent;

    trc_ent_t          rec_ent;
    logic [PW-1:0]     cmp_idx;
    logic [PW-1:0]     ld_idx;
    logic [TRC_DW-1:0] ld_mem_val;
    logic [IW-1:0]     lcount;
    trc_ent_t          div_exp;
    trc_ent_t          div_got;

    assign mode         = trc_mode_e'(mode_i);
    assign in_replay    = (mode == MODE_REPLAY);
    assign replay_enter = in_replay && (prev_mode_q != MODE_REPLAY);
    assign clr_replay   = win_start_i || replay_enter;

    assign ev_ent.kind  = ev_kind_e'(ev_kind_i);
    assign ev_ent.addr  = ev_addr_i;
    assign ev_ent.data  = ev_data_i;

    assign rec_wr = (mode == MODE_RECORD) && ev_valid_i && !win_start_i;
    assign cmp_en = in_replay && ev_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_mode_q <= MODE_IDLE;
        end else begin
            prev_mode_q <= mode;
        end
    end

    trc_store #(.DEPTH(DEPTH), .IW(IW), .PW(PW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (win_start_i),
        .wr_en   (rec_wr),
        .wr_ent  (ev_ent),
        .rd_idx  (cmp_idx),
        .rd_ent  (rec_ent),
        .lrd_idx (ld_idx),
        .lrd_val (ld_mem_val),
        .count   (rec_count_o),
        .lcount  (lcount),
        .full    (win_full_o)
    );

    trc_load_feed #(.DEPTH(DEPTH), .IW(IW), .PW(PW)) u_feed (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_replay),
        .active  (in_replay),
        .req     (ld_req_i),
        .lcount  (lcount),
        .mem_val (ld_mem_val),
        .mem_idx (ld_idx),
        .avail   (ld_avail_o),
        .value   (ld_data_o)
    );

    trc_compare #(.DEPTH(DEPTH), .IW(IW), .PW(PW)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_replay),
        .ev_en      (cmp_en),
        .got        (ev_ent),
        .count      (rec_count_o),
        .rec_ent    (rec_ent),
        .rd_idx     (cmp_idx),
        .diverged   (diverged_o),
        .div_index  (div_index_o),
        .div_exp    (div_exp),
        .div_got    (div_got),
        .match_done (match_done_o)
    );

    assign div_exp_kind_o = div_exp.kind;
    assign div_exp_addr_o = div_exp.addr;
    assign div_exp_data_o = div_exp.data;
    assign div_got_kind_o = div_got.kind;
    assign div_got_addr_o = div_got.addr;
    assign div_got_data_o = div_got.data;

endmodule

// File: rtl/trace_div_checker_chk.sv
module trace_div_checker_chk #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_i,
    input logic          win_start_i,
    input logic [IW-1:0] rec_count_o,
    input logic          win_full_o,
    input logic          match_done_o,
    input logic          diverged_o,
    input logic [IW-1:0] div_index_o
);

    AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        win_start_i |=> (rec_count_o == '0) && !win_full_o && !diverged_o && !match_done_o) // R1
        else $error("window start did not clear state");

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'd1 && !win_start_i) |=> $stable(rec_count_o)) // R2
        else $error("count moved outside record mode");

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        rec_count_o <= IW'(DEPTH)) // R3
        else $error("count beyond depth");

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        win_full_o |-> (rec_count_o == IW'(DEPTH))) // R3
        else $error("full flag without full count");

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        match_done_o |=> !match_done_o) // R5
        else $error("completion pulse longer than one cycle");

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        match_done_o |-> !diverged_o) // R5
        else $error("completion with divergence");

    AST_DIV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (diverged_o && mode_i == 2'd2 && $past(mode_i) == 2'd2 && !win_start_i)
            |=> diverged_o && $stable(div_index_o)) // R7
        else $error("divergence record changed");

endmodule

bind trace_div_checker trace_div_checker_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .win_start_i  (win_start_i),
    .rec_count_o  (rec_count_o),
    .win_full_o   (win_full_o),
    .match_done_o (match_done_o),
    .diverged_o   (diverged_o),
    .div_index_o  (div_index_o)
);

// File: tb/test_trace_div_checker.sv
module test_trace_div_checker;

    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_i;
    logic        win_start_i;
    logic        ev_valid_i;
    logic [1:0]  ev_kind_i;
    logic [63:0] ev_addr_i;
    logic [63:0] ev_data_i;
    logic        ld_req_i;
    logic        ld_avail_o;
    logic [63:0] ld_data_o;
    logic [IW-1:0] rec_count_o;
    logic        win_full_o;
    logic        match_done_o;
    logic        diverged_o;
    logic [IW-1:0] div_index_o;
    logic [1:0]  div_exp_kind_o;
    logic [63:0] div_exp_addr_o;
    logic [63:0] div_exp_data_o;
    logic [1:0]  div_got_kind_o;
    logic [63:0] div_got_addr_o;
    logic [63:0] div_got_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // recorded window: kind, addr, data
    logic [1:0]  tk [5] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd0};
    logic [63:0] ta [5] = '{64'h100, 64'h2000, 64'h3000, 64'h2008, 64'h104};
    logic [63:0] td [5] = '{64'h1, 64'hAAAA, 64'h55, 64'hBBBB, 64'h0};

    always #4 clk = ~clk;

    trace_div_checker #(.DEPTH(DEPTH)) i_trace_div_checker (
        .clk(clk), .rst(rst), .mode_i(mode_i), .win_start_i(win_start_i),
        .ev_valid_i(ev_valid_i), .ev_kind_i(ev_kind_i), .ev_addr_i(ev_addr_i),
        .ev_data_i(ev_data_i), .ld_req_i(ld_req_i), .ld_avail_o(ld_avail_o),
        .ld_data_o(ld_data_o), .rec_count_o(rec_count_o), .win_full_o(win_full_o),
        .match_done_o(match_done_o), .diverged_o(diverged_o), .div_index_o(div_index_o),
        .div_exp_kind_o(div_exp_kind_o), .div_exp_addr_o(div_exp_addr_o),
        .div_exp_data_o(div_exp_data_o), .div_got_kind_o(div_got_kind_o),
        .div_got_addr_o(div_got_addr_o), .div_got_data_o(div_got_data_o)
    );

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk); mode_i = m;
        @(negedge clk);
    endtask

    task automatic start_window();
        @(negedge clk); win_start_i = 1'b1;
        @(negedge clk); win_start_i = 1'b0;
    endtask

    task automatic send_ev(logic [1:0] k, logic [63:0] a, logic [63:0] d);
        @(negedge clk);
        ev_valid_i = 1'b1; ev_kind_i = k; ev_addr_i = a; ev_data_i = d;
        @(negedge clk);
        ev_valid_i = 1'b0;
    endtask

    task automatic pull_load();
        @(negedge clk); ld_req_i = 1'b1;
        @(negedge clk); ld_req_i = 1'b0;
    endtask

    task automatic enter_replay();
        set_mode(2'd0);
        set_mode(2'd2);
    endtask

    task automatic t_reset();
        chk("R1 count after reset", 64'(rec_count_o), 0);
        chk("R1 full after reset", 64'(win_full_o), 0);
        chk("R1 diverged after reset", 64'(diverged_o), 0);
        chk("R1 done after reset", 64'(match_done_o), 0);
        chk("R1 load avail after reset", 64'(ld_avail_o), 0);
    endtask

    task automatic t_record();
        start_window();
        set_mode(2'd1);
        for (int i = 0; i < 5; i++) send_ev(tk[i], ta[i], td[i]);
        chk("R2 count after five records", 64'(rec_count_o), 5);
        set_mode(2'd0);
        send_ev(2'd2, 64'h9999, 64'h1);
        chk("R2 idle event ignored", 64'(rec_count_o), 5);
    endtask

    task automatic t_load_feed();
        set_mode(2'd2);
        send_ev(tk[0], ta[0], td[0]);
        chk("R2 replay event not recorded", 64'(rec_count_o), 5);
        chk("R4 first load avail", 64'(ld_avail_o), 1);
        chk("R4 first load value", ld_data_o, 64'hAAAA);
        pull_load();
        chk("R4 second load value", ld_data_o, 64'hBBBB);
        pull_load();
        chk("R4 exhausted avail", 64'(ld_avail_o), 0);
        chk("R4 exhausted value", ld_data_o, 0);
        set_mode(2'd0);
        chk("R4 no avail outside replay", 64'(ld_avail_o), 0);
    endtask

    task automatic t_match();
        enter_replay();
        chk("R10 load rewound", ld_data_o, 64'hAAAA);
        for (int i = 0; i < 4; i++) begin
            send_ev(tk[i], ta[i], td[i]);
            chk("R5 no early done", 64'(match_done_o), 0);
        end
        send_ev(tk[4], ta[4], td[4]);
        chk("R5 done pulse", 64'(match_done_o), 1);
        chk("R5 no divergence", 64'(diverged_o), 0);
        @(negedge clk);
        chk("R5 done one cycle", 64'(match_done_o), 0);
    endtask

    task automatic t_mismatch();
        enter_replay();
        send_ev(tk[0], ta[0], td[0]);
        send_ev(tk[1], ta[1], td[1]);
        send_ev(2'd2, 64'h3000, 64'h56);
        chk("R6 diverged", 64'(diverged_o), 1);
        chk("R6 index", 64'(div_index_o), 2);
        chk("R6 exp kind", 64'(div_exp_kind_o), 2);
        chk("R6 exp addr", div_exp_addr_o, 64'h3000);
        chk("R6 exp data", div_exp_data_o, 64'h55);
        chk("R6 got data", div_got_data_o, 64'h56);
        chk("R6 got addr", div_got_addr_o, 64'h3000);
        send_ev(tk[3], ta[3], td[3]);
        send_ev(tk[4], ta[4], td[4]);
        chk("R7 no done after divergence", 64'(match_done_o), 0);
        chk("R7 index held", 64'(div_index_o), 2);
        chk("R7 got data held", div_got_data_o, 64'h56);
        chk("R7 still diverged", 64'(diverged_o), 1);
    endtask

    task automatic t_kind();
        enter_replay();
        chk("R10 divergence cleared on re-entry", 64'(diverged_o), 0);
        send_ev(2'd1, ta[0], td[0]);
        chk("R9 kind-only divergence", 64'(diverged_o), 1);
        chk("R9 kind-only index", 64'(div_index_o), 0);
        chk("R9 exp kind branch", 64'(div_exp_kind_o), 0);
        chk("R9 got kind load", 64'(div_got_kind_o), 1);
    endtask

    task automatic t_beyond();
        enter_replay();
        for (int i = 0; i < 5; i++) send_ev(tk[i], ta[i], td[i]);
        chk("R5 done before extra event", 64'(match_done_o), 1);
        send_ev(2'd0, 64'h900, 64'h1);
        chk("R8 extra event diverges", 64'(diverged_o), 1);
        chk("R8 extra index", 64'(div_index_o), 5);
        chk("R8 exp addr zero", div_exp_addr_o, 0);
        chk("R8 exp data zero", div_exp_data_o, 0);
        chk("R8 exp kind zero", 64'(div_exp_kind_o), 0);
        chk("R8 got addr", div_got_addr_o, 64'h900);
    endtask

    task automatic t_full();
        set_mode(2'd0);
        start_window();
        chk("R1 window start clears count", 64'(rec_count_o), 0);
        set_mode(2'd1);
        for (int i = 0; i < DEPTH - 1; i++) send_ev(2'd2, 64'(i), 64'(i));
        chk("R3 not full one short", 64'(win_full_o), 0);
        send_ev(2'd2, 64'hF0, 64'hF0);
        chk("R3 full at depth", 64'(win_full_o), 1);
        send_ev(2'd2, 64'hF1, 64'hF1);
        chk("R3 count held when full", 64'(rec_count_o), DEPTH);
        start_window();
        chk("R1 full cleared", 64'(win_full_o), 0);
        chk("R1 count cleared", 64'(rec_count_o), 0);
    endtask

    initial begin
        rst = 1'b1; mode_i = 2'd0; win_start_i = 1'b0; ev_valid_i = 1'b0;
        ev_kind_i = '0; ev_addr_i = '0; ev_data_i = '0; ld_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_record();
        t_load_feed();
        t_match();
        t_mismatch();
        t_kind();
        t_beyond();
        t_full();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule